// File: doc/BRIEF.md
# Two-Read One-Write Register File with Write Forwarding

This block is a small general-purpose register file: eight entries of eight bits each, with two read ports that answer combinationally and one write port that updates on the rising clock edge. Each read port has its own address, so two different registers (or the same one twice) can be fetched together in one cycle.

A read whose address matches a write happening in the same cycle returns the data being written, not the old stored value. This lets a consumer see a result in the cycle it is produced. Entry zero is a constant: it always reads as zero, and writes aimed at it are dropped. A synchronous reset clears every entry. Reset takes priority over a write in the same cycle, and during reset the forwarding path is switched off.

The read and write pins are plain level signals with no handshake. Every read is answered in the cycle it is asked, and a write with enable high always completes at the next edge, so there is no back-pressure.

Top module: `regfile_fwd2r1w`

## Requirements
- R1: The two read ports are independent. Each returns, in the same cycle and with no clock edge between, the contents of the entry named by its own 3-bit address.
- R2: When `wr_en_i` is 1 and reset is low, the entry named by `wr_addr_i` takes `wr_data_i` at the rising clock edge. Every other entry keeps its value.
- R3: When `wr_en_i` is 1, reset is low, and a read address equals a nonzero `wr_addr_i`, that read port returns `wr_data_i` in the same cycle.
- R4: A read of address 0 always returns 0x00, even while a write to address 0 is in progress. A write to address 0 has no effect on any entry.
- R5: When `rst_i` is 1 at a rising edge, every entry reads 0x00 after that edge.
- R6: In a cycle with `rst_i` at 1, a write is not performed and no forwarding occurs. The read ports return the stored contents.
- R7: When both read ports select the same address, they return the same value, including when that value is forwarded.
- R8: When `wr_en_i` is 0, no entry changes at the clock edge and no forwarding occurs, whatever is on the write address and data pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes and reset act on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high; clears all entries |
| wr_en_i | input | 1 | Write enable, active high |
| wr_addr_i | input | 3 | Entry to be written |
| wr_data_i | input | 8 | Data to be written |
| rd_addr_a_i | input | 3 | Read port A address |
| rd_data_a_o | output | 8 | Read port A data, combinational |
| rd_addr_b_i | input | 3 | Read port B address |
| rd_data_b_o | output | 8 | Read port B data, combinational |

## Verification
The assertions assume that reset is held for at least one edge before any read is trusted, because the stored entries are undefined until the first reset. They also assume that the write pins are stable around each rising edge, so the stored value and the forwarded value come from the same sample. The bench drives every input on the falling edge and holds reset for two edges at the start. Reset is asserted again later, only together with a write, to exercise the priority rule.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned RF_DEF_ENTRIES = 8;
  localparam int unsigned RF_DEF_WIDTH   = 8;
endpackage

// File: rtl/rf_store.sv
module rf_store #(
  parameter int unsigned ENTRIES = rf_pkg::RF_DEF_ENTRIES,
  parameter int unsigned WIDTH   = rf_pkg::RF_DEF_WIDTH,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic                            clk_i,
  input  logic                            rst_i,
  input  logic                            wr_en_i,
  input  logic [AW-1:0]                   wr_addr_i,
  input  logic [WIDTH-1:0]                wr_data_i,
  output logic [ENTRIES-1:0][WIDTH-1:0]   entries_o
);
  // entry zero has no flops: constant zero
  assign entries_o[0] = '0;

  for (genvar gi = 1; gi < ENTRIES; gi++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        entries_o[gi] <= '0;
      end else if (wr_en_i && (wr_addr_i == AW'(gi))) begin
        entries_o[gi] <= wr_data_i;
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (entries_o == '0)); // R5

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && (wr_addr_i != '0)) |=> (entries_o[$past(wr_addr_i)] == $past(wr_data_i))); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_en_i |=> $stable(entries_o)); // R8
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned ENTRIES = rf_pkg::RF_DEF_ENTRIES,
  parameter int unsigned WIDTH   = rf_pkg::RF_DEF_WIDTH,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic                            clk_i,
  input  logic                            rst_i,
  input  logic [ENTRIES-1:0][WIDTH-1:0]   entries_i,
  input  logic                            wr_en_i,
  input  logic [AW-1:0]                   wr_addr_i,
  input  logic [WIDTH-1:0]                wr_data_i,
  input  logic [AW-1:0]                   rd_addr_i,
  output logic [WIDTH-1:0]                rd_data_o
);
  logic fwd_hit;

  // forward only for a live, nonzero, matching write outside reset
  assign fwd_hit = wr_en_i && !rst_i && (rd_addr_i != '0) && (rd_addr_i == wr_addr_i);

  always_comb begin
    if (rd_addr_i == '0) begin
      rd_data_o = '0;
    end else if (fwd_hit) begin
      rd_data_o = wr_data_i;
    end else begin
      rd_data_o = entries_i[rd_addr_i];
    end
  end

  AST_ZERO_ENTRY: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_addr_i == '0) |-> (rd_data_o == '0)); // R4

  AST_FORWARD: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && (wr_addr_i != '0) && (rd_addr_i == wr_addr_i)) |-> (rd_data_o == wr_data_i)); // R3

  AST_NO_FWD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_en_i |-> (rd_data_o == entries_i[rd_addr_i])); // R8
endmodule

// File: rtl/regfile_fwd2r1w.sv
module regfile_fwd2r1w #(
  parameter int unsigned ENTRIES = rf_pkg::RF_DEF_ENTRIES,
  parameter int unsigned WIDTH   = rf_pkg::RF_DEF_WIDTH,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_addr_a_i,
  output logic [WIDTH-1:0] rd_data_a_o,
  input  logic [AW-1:0]    rd_addr_b_i,
  output logic [WIDTH-1:0] rd_data_b_o
);
  localparam int unsigned PORTS = 2;

  logic [ENTRIES-1:0][WIDTH-1:0] entries;
  logic [PORTS-1:0][AW-1:0]      rd_addr;
  logic [PORTS-1:0][WIDTH-1:0]   rd_data;

  assign rd_addr[0]  = rd_addr_a_i;
  assign rd_addr[1]  = rd_addr_b_i;
  assign rd_data_a_o = rd_data[0];
  assign rd_data_b_o = rd_data[1];

  rf_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .entries_o (entries)
  );

  for (genvar gp = 0; gp < PORTS; gp++) begin : g_port
    rf_read_port #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_rd (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .entries_i (entries),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .rd_addr_i (rd_addr[gp]),
      .rd_data_o (rd_data[gp])
    );
  end

  AST_PORTS_AGREE: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_addr_a_i == rd_addr_b_i) |-> (rd_data_a_o == rd_data_b_o)); // R7
endmodule

// File: tb/regfile_fwd2r1w_tb.sv
module regfile_fwd2r1w_tb;
  logic       clk = 1'b0;
  logic       rst_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_addr_a_i = '0;
  logic [2:0] rd_addr_b_i = '0;
  logic [7:0] rd_data_a_o;
  logic [7:0] rd_data_b_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] exp_a;
    logic [7:0] exp_b;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] mdl [8];
  event       sample_ev;

  always #5 clk = ~clk;

  regfile_fwd2r1w u_dut (
    .clk_i(clk), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_a_i(rd_addr_a_i), .rd_data_a_o(rd_data_a_o),
    .rd_addr_b_i(rd_addr_b_i), .rd_data_b_o(rd_data_b_o)
  );

  // reference model updated at the clock edge from the requirements
  always @(posedge clk) begin
    if (rst_i) begin
      for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    end else if (wr_en_i && wr_addr_i != 3'd0) begin
      mdl[wr_addr_i] = wr_data_i;
    end
  end

  function automatic logic [7:0] predict(logic [2:0] ra);
    if (ra == 3'd0) return 8'h00;
    if (wr_en_i && !rst_i && ra == wr_addr_i) return wr_data_i;
    return mdl[ra];
  endfunction

  task automatic drive(input logic rst, input logic we, input logic [2:0] wa,
                       input logic [7:0] wd, input logic [2:0] ra,
                       input logic [2:0] rb, input string tag);
    exp_t e;
    @(negedge clk);
    rst_i = rst; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    rd_addr_a_i = ra; rd_addr_b_i = rb;
    #1;
    e.exp_a = predict(ra);
    e.exp_b = predict(rb);
    e.tag   = tag;
    sb_q.push_back(e);
    -> sample_ev;
  endtask

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      exp_t e;
      @(sample_ev);
      #1;
      e = sb_q.pop_front();
      checks++;
      if (rd_data_a_o !== e.exp_a) begin
        fails++;
        $display("FAIL %s port A: actual %02h expected %02h", e.tag, rd_data_a_o, e.exp_a);
      end
      checks++;
      if (rd_data_b_o !== e.exp_b) begin
        fails++;
        $display("FAIL %s port B: actual %02h expected %02h", e.tag, rd_data_b_o, e.exp_b);
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    repeat (2) @(posedge clk);
    // R5: reset state, all entries zero
    for (int i = 0; i < 8; i += 2) drive(0, 0, 0, 8'h00, 3'(i), 3'(i + 1), "R5 reset state");
    // R3 / R4: write each entry, forwarded on port A, port B on zero entry
    for (int i = 1; i < 8; i++) drive(0, 1, 3'(i), 8'(i * 17 + 3), 3'(i), 3'd0, "R3 forward");
    // R1 / R2: independent reads of stored values
    for (int i = 1; i < 8; i++) drive(0, 0, 0, 8'h00, 3'(i), 3'(8 - i), "R1 R2 readback");
    // R8: disabled write is ignored, no forwarding
    drive(0, 0, 3'd2, 8'hAA, 3'd2, 3'd5, "R8 no write same cycle");
    drive(0, 0, 3'd0, 8'h00, 3'd2, 3'd5, "R8 no write after");
    // R4: write to entry zero discarded
    drive(0, 1, 3'd0, 8'hFF, 3'd0, 3'd0, "R4 zero during write");
    drive(0, 0, 3'd0, 8'h00, 3'd0, 3'd1, "R4 zero after write");
    // R7: both ports on the same address, forwarded and stored
    drive(0, 1, 3'd6, 8'h3C, 3'd6, 3'd6, "R7 same addr forward");
    drive(0, 0, 3'd0, 8'h00, 3'd6, 3'd6, "R7 same addr stored");
    // R6: reset wins over write, no forwarding in reset cycle
    drive(1, 1, 3'd3, 8'h5A, 3'd3, 3'd6, "R6 reset priority");
    for (int i = 0; i < 8; i += 2) drive(0, 0, 0, 8'h00, 3'(i), 3'(i + 1), "R5 R6 cleared");
    // R2: overwrite and check neighbours unchanged
    drive(0, 1, 3'd7, 8'h81, 3'd6, 3'd1, "R2 neighbours");
    drive(0, 0, 3'd0, 8'h00, 3'd7, 3'd6, "R2 overwrite");
    @(negedge clk);
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule